// File: doc/BRIEF.md
# Port Overcurrent Fault Integrator

This block watches the load current of one powered port and decides when the port must be switched off. Each millisecond tick it compares a digitised current code, in mA, against a limit. The limit depends on the detected power class, on a two-bit strap setting for the highest class and on whether the port is still ramping up or is fully powered. The result drives an up/down fault accumulator. Overload ticks add sixteen counts and quiet ticks remove one. A full accumulator requests power-off with an overcurrent cause. A run of short overloads therefore adds up to a fault, and a tripped port stays off until the accumulator has drained back to zero.

A second timer handles DC load removal. While the port is fully powered and the option is enabled, a current below 8 mA that lasts long enough requests power-off with a disconnect cause. The surrounding port sequencer applies the power-off, reports power on and off through `portOn`, and waits for `restartOk` before it powers the port again.

Top module: `port_fault_integrator`

## Requirements
- R1: Thresholds per `pdClass` (3-bit code). Codes 0–3, and any code above 5, use a startup limit of 420 mA and an overcurrent threshold of 370 mA. Code 4 uses 720/634 mA. Code 5 with `class5Sel` = 00 also uses 720/634 mA. A current counts as overload only when it is strictly greater than the active threshold.
- R2: Code 5 with `class5Sel` = 01 (bit 0 set) uses 850/748 mA. With 10 it uses 900/792 mA. With 11 it uses 950/836 mA.
- R3: While `inStartup` is 1 the startup limit is active. Otherwise the overcurrent threshold is active.
- R4: While the port is on, each overload tick adds 16 to the accumulator, which is full at 960. A 60th overload tick in a row fills it. On the next clock edge `offReq` goes to 1 with `offCause` = 1, and a 59th tick in a row does not trip.
- R5: A tick without overload removes 1 count. With one overload tick followed by 16 quiet ticks, repeated, the port never trips.
- R6: `offReq` stays 1 until `portOn` is 0. A trip does not clear the accumulator, which keeps draining by 1 per tick. `restartOk` is 1 only when the accumulator is zero and no trip is pending, so after a trip it returns 960 ticks later.
- R7: The accumulator saturates: it never goes below 0 and never goes above 960.
- R8: The first clock with `portOn` = 1 after it was off clears the accumulator and the disconnect timer. Counting starts on the next tick.
- R9: The disconnect timer counts when `portOn` = 1, `inStartup` = 0, `dcDiscEn` = 1 and `curMa` < 8. When any of these fails it returns to zero. It trips the clock after its 350th tick, with `offCause` = 2. A current of 8 mA or more, a 0 on `dcDiscEn`, or `inStartup` = 1 prevents this trip.
- R10: `offCause` is 0 whenever `offReq` is 0. If both conditions are met together, overcurrent wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| msTick | input | 1 | One-cycle pulse per millisecond |
| curMa | input | 11 | Load current code in mA |
| pdClass | input | 3 | Detected power class |
| class5Sel | input | 2 | Highest-class strap setting, bit 0 first strap low, bit 1 second strap low |
| portOn | input | 1 | Port is powered (startup or normal) |
| inStartup | input | 1 | Port is in its startup interval |
| dcDiscEn | input | 1 | DC load-disconnect enable |
| offReq | output | 1 | Power-off request, held until portOn falls |
| offCause | output | 2 | 0 none, 1 overcurrent, 2 disconnect |
| restartOk | output | 1 | Port may be powered again |

## Verification
Counts change on the clock edge that samples a tick. A trip appears on the next edge, so `offReq` is due one clock after the 60th overload tick or the 350th low-current tick. `restartOk` follows the edge on which the drain reaches zero. The bench drives inputs on falling edges and advances a behavioural model on each rising edge. It compares all outputs on the following falling edge, which places every comparison after the edge that produced the value. Directed checks are taken after tick counts chosen one short of and exactly at each boundary.

// File: rtl/pfi_pkg.sv
package pfi_pkg;

  localparam int CUR_W = 11;

  typedef enum logic [1:0] {
    CAUSE_NONE       = 2'd0,
    CAUSE_OVERCUR    = 2'd1,
    CAUSE_DISCONNECT = 2'd2
  } cause_e;

  typedef struct packed {
    logic cntClr;
    logic cntUp;
    logic cntDown;
    logic discClr;
    logic discInc;
  } strobes_t;

  typedef struct packed {
    logic [CUR_W-1:0] limMa;
    logic [CUR_W-1:0] ocMa;
  } thr_t;

  function automatic thr_t pickThresholds(input logic [2:0] cls, input logic [1:0] sel);
    thr_t t;
    t.limMa = CUR_W'(420);
    t.ocMa  = CUR_W'(370);
    if (cls == 3'd4 || (cls == 3'd5 && sel == 2'b00)) begin
      t.limMa = CUR_W'(720);
      t.ocMa  = CUR_W'(634);
    end else if (cls == 3'd5) begin
      case (sel)
        2'b01:   begin t.limMa = CUR_W'(850); t.ocMa = CUR_W'(748); end
        2'b10:   begin t.limMa = CUR_W'(900); t.ocMa = CUR_W'(792); end
        default: begin t.limMa = CUR_W'(950); t.ocMa = CUR_W'(836); end
      endcase
    end
    return t;
  endfunction

endpackage

// File: rtl/pfi_datapath.sv
module pfi_datapath
  import pfi_pkg::*;
#(
  parameter int FAULT_TICKS = 60,
  parameter int DRAIN_DIV   = 16,
  parameter int DISC_TICKS  = 350,
  parameter int DISC_MA     = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CUR_W-1:0] curMa,
  input  logic [2:0]       pdClass,
  input  logic [1:0]       class5Sel,
  input  logic             inStartup,
  input  strobes_t         strb,
  output logic             overload,
  output logic             lowCurrent,
  output logic             cntFull,
  output logic             cntZero,
  output logic             discDone
);

  localparam int FULL   = FAULT_TICKS * DRAIN_DIV;
  localparam int CNT_W  = $clog2(FULL + 1);
  localparam int DISC_W = $clog2(DISC_TICKS + 1);
  localparam logic [CNT_W-1:0]  FULL_C  = CNT_W'(FULL);
  localparam logic [CNT_W-1:0]  STEP_C  = CNT_W'(DRAIN_DIV);
  localparam logic [CNT_W-1:0]  NEAR_C  = CNT_W'(FULL - DRAIN_DIV);
  localparam logic [DISC_W-1:0] DISC_C  = DISC_W'(DISC_TICKS);

  thr_t             thr;
  logic [CUR_W-1:0] activeThr;
  logic [CNT_W-1:0] faultCnt;
  logic [DISC_W-1:0] discCnt;

  always_comb begin
    thr        = pickThresholds(pdClass, class5Sel);
    activeThr  = inStartup ? thr.limMa : thr.ocMa;
    overload   = curMa > activeThr;
    lowCurrent = curMa < CUR_W'(DISC_MA);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      faultCnt <= '0;
    end else if (strb.cntClr) begin
      faultCnt <= '0;
    end else if (strb.cntUp) begin
      faultCnt <= (faultCnt > NEAR_C) ? FULL_C : faultCnt + STEP_C;
    end else if (strb.cntDown && faultCnt != '0) begin
      faultCnt <= faultCnt - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      discCnt <= '0;
    end else if (strb.discClr) begin
      discCnt <= '0;
    end else if (strb.discInc && discCnt != DISC_C) begin
      discCnt <= discCnt + DISC_W'(1);
    end
  end

  assign cntFull  = (faultCnt == FULL_C);
  assign cntZero  = (faultCnt == '0);
  assign discDone = (discCnt == DISC_C);

  p_cnt_range_r7: assert property (@(posedge clk) disable iff (!rstN)
    faultCnt <= FULL_C);

  p_drain_slow_r5: assert property (@(posedge clk) disable iff (!rstN)
    (faultCnt < $past(faultCnt)) |-> ($past(strb.cntClr) || ($past(faultCnt) - faultCnt == CNT_W'(1))));

  p_disc_range_r9: assert property (@(posedge clk) disable iff (!rstN)
    discCnt <= DISC_C);

endmodule

// File: rtl/pfi_control.sv
module pfi_control
  import pfi_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     msTick,
  input  logic     portOn,
  input  logic     inStartup,
  input  logic     dcDiscEn,
  input  logic     overload,
  input  logic     lowCurrent,
  input  logic     cntFull,
  input  logic     cntZero,
  input  logic     discDone,
  output strobes_t strb,
  output logic     offReq,
  output cause_e   offCause,
  output logic     restartOk
);

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_TRIP} state_e;

  state_e stateQ, stateD;
  cause_e causeQ, causeD;

  always_comb begin
    stateD = stateQ;
    causeD = causeQ;
    strb   = '0;
    unique case (stateQ)
      ST_IDLE: begin
        if (portOn) begin
          stateD      = ST_RUN;
          strb.cntClr = 1'b1;
          strb.discClr = 1'b1;
        end else begin
          strb.cntDown = msTick;
          strb.discClr = 1'b1;
        end
      end
      ST_RUN: begin
        if (!portOn) begin
          stateD       = ST_IDLE;
          strb.cntDown = msTick;
          strb.discClr = 1'b1;
        end else if (cntFull) begin
          stateD = ST_TRIP;
          causeD = CAUSE_OVERCUR;
        end else if (discDone) begin
          stateD = ST_TRIP;
          causeD = CAUSE_DISCONNECT;
        end else begin
          strb.cntUp   = msTick && overload;
          strb.cntDown = msTick && !overload;
          if (!inStartup && dcDiscEn && lowCurrent) begin
            strb.discInc = msTick;
          end else begin
            strb.discClr = 1'b1;
          end
        end
      end
      default: begin
        strb.cntDown = msTick;
        strb.discClr = 1'b1;
        if (!portOn) begin
          stateD = ST_IDLE;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      causeQ <= CAUSE_NONE;
    end else begin
      stateQ <= stateD;
      causeQ <= causeD;
    end
  end

  assign offReq    = (stateQ == ST_TRIP);
  assign offCause  = offReq ? causeQ : CAUSE_NONE;
  assign restartOk = !offReq && cntZero;

  p_cause_valid_r10: assert property (@(posedge clk) disable iff (!rstN)
    offReq |-> (offCause != CAUSE_NONE));

  p_trip_holds_r6: assert property (@(posedge clk) disable iff (!rstN)
    (offReq && portOn) |=> offReq);

  p_entry_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_IDLE && portOn) |=> cntZero);

  p_oc_trip_r4: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_RUN && portOn && cntFull) |=> (offReq && offCause == CAUSE_OVERCUR));

endmodule

// File: rtl/port_fault_integrator.sv
module port_fault_integrator
  import pfi_pkg::*;
#(
  parameter int FAULT_TICKS = 60,
  parameter int DRAIN_DIV   = 16,
  parameter int DISC_TICKS  = 350,
  parameter int DISC_MA     = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             msTick,
  input  logic [CUR_W-1:0] curMa,
  input  logic [2:0]       pdClass,
  input  logic [1:0]       class5Sel,
  input  logic             portOn,
  input  logic             inStartup,
  input  logic             dcDiscEn,
  output logic             offReq,
  output logic [1:0]       offCause,
  output logic             restartOk
);

  strobes_t strb;
  cause_e   causeW;
  logic     overload, lowCurrent, cntFull, cntZero, discDone;

  pfi_datapath #(
    .FAULT_TICKS(FAULT_TICKS),
    .DRAIN_DIV  (DRAIN_DIV),
    .DISC_TICKS (DISC_TICKS),
    .DISC_MA    (DISC_MA)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .curMa     (curMa),
    .pdClass   (pdClass),
    .class5Sel (class5Sel),
    .inStartup (inStartup),
    .strb      (strb),
    .overload  (overload),
    .lowCurrent(lowCurrent),
    .cntFull   (cntFull),
    .cntZero   (cntZero),
    .discDone  (discDone)
  );

  pfi_control ctl_i (
    .clk       (clk),
    .rstN      (rstN),
    .msTick    (msTick),
    .portOn    (portOn),
    .inStartup (inStartup),
    .dcDiscEn  (dcDiscEn),
    .overload  (overload),
    .lowCurrent(lowCurrent),
    .cntFull   (cntFull),
    .cntZero   (cntZero),
    .discDone  (discDone),
    .strb      (strb),
    .offReq    (offReq),
    .offCause  (causeW),
    .restartOk (restartOk)
  );

  assign offCause = causeW;

endmodule

// File: tb/port_fault_integrator_tb_top.sv
module port_fault_integrator_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        msTick = 1'b0;
  logic [10:0] curMa = '0;
  logic [2:0]  pdClass = '0;
  logic [1:0]  class5Sel = '0;
  logic        portOn = 1'b0;
  logic        inStartup = 1'b0;
  logic        dcDiscEn = 1'b0;
  logic        offReq;
  logic [1:0]  offCause;
  logic        restartOk;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  port_fault_integrator dut_i (
    .clk(clk), .rstN(rstN), .msTick(msTick), .curMa(curMa),
    .pdClass(pdClass), .class5Sel(class5Sel), .portOn(portOn),
    .inStartup(inStartup), .dcDiscEn(dcDiscEn),
    .offReq(offReq), .offCause(offCause), .restartOk(restartOk)
  );

  // Reference model: accumulator, disconnect timer, mode 0 off / 1 on / 2 tripped
  int mCnt = 0, mDisc = 0, mMode = 0, mCause = 0;

  function automatic int limOf(input int cls, input int sel, input bit startup);
    int lim, oc;
    lim = 420; oc = 370;
    if (cls == 4 || (cls == 5 && sel == 0)) begin lim = 720; oc = 634; end
    else if (cls == 5 && sel == 1) begin lim = 850; oc = 748; end
    else if (cls == 5 && sel == 2) begin lim = 900; oc = 792; end
    else if (cls == 5 && sel == 3) begin lim = 950; oc = 836; end
    return startup ? lim : oc;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mCnt = 0; mDisc = 0; mMode = 0; mCause = 0;
    end else begin
      bit over;
      over = int'(curMa) > limOf(int'(pdClass), int'(class5Sel), inStartup);
      if (mMode == 0) begin
        if (portOn) begin mMode = 1; mCnt = 0; mDisc = 0; end
        else begin if (msTick && mCnt > 0) mCnt--; mDisc = 0; end
      end else if (mMode == 1) begin
        if (!portOn) begin mMode = 0; if (msTick && mCnt > 0) mCnt--; mDisc = 0; end
        else if (mCnt == 960) begin mMode = 2; mCause = 1; end
        else if (mDisc == 350) begin mMode = 2; mCause = 2; end
        else begin
          if (msTick) mCnt = over ? ((mCnt + 16 > 960) ? 960 : mCnt + 16) : ((mCnt > 0) ? mCnt - 1 : 0);
          if (!inStartup && dcDiscEn && curMa < 8) begin if (msTick) mDisc++; end
          else mDisc = 0;
        end
      end else begin
        if (msTick && mCnt > 0) mCnt--;
        mDisc = 0;
        if (!portOn) mMode = 0;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Per-clock comparison against the model, away from the rising edge
  always @(negedge clk) begin
    if (rstN) begin
      int eReq, eCause, eOk;
      eReq = (mMode == 2);
      eCause = eReq ? mCause : 0;
      eOk = (mMode != 2 && mCnt == 0);
      check(offReq == eReq[0], "R4/R6 offReq vs model", offReq, eReq);
      check(int'(offCause) == eCause, "R10 offCause vs model", offCause, eCause);
      check(restartOk == eOk[0], "R6 restartOk vs model", restartOk, eOk);
    end
  end

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      msTick = 1'b1; @(negedge clk);
      msTick = 1'b0; @(negedge clk);
    end
  endtask

  task automatic powerOn(input bit startup);
    inStartup = startup; portOn = 1'b1; @(negedge clk);
  endtask

  task automatic powerOff();
    portOn = 1'b0; @(negedge clk);
  endtask

  // Apply thr (no trip) or thr+1 (trip) for 60 ticks
  task automatic threshold(input int cls, input int sel, input bit startup, input int thr, input string req);
    pdClass = 3'(cls); class5Sel = 2'(sel);
    powerOn(startup);
    curMa = 11'(thr); ticks(60); @(negedge clk);
    check(offReq == 1'b0, req, offReq, 0);
    powerOff(); powerOn(startup);
    curMa = 11'(thr + 1); ticks(60);
    check(offReq == 1'b1 && offCause == 2'd1, req, {offReq, offCause}, 5);
    powerOff();
    curMa = '0;
  endtask

  initial begin
    #800000;
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(offReq == 0 && offCause == 0 && restartOk == 1, "reset state", {offReq, offCause, restartOk}, 1);

    // R1 / R2 / R3 thresholds, powered and startup
    threshold(0, 0, 0, 370, "R1 class0 oc");
    threshold(2, 3, 1, 420, "R1 R3 class2 startup");
    threshold(7, 3, 0, 370, "R1 code7 oc");
    threshold(4, 0, 0, 634, "R1 class4 oc");
    threshold(4, 0, 1, 720, "R3 class4 startup");
    threshold(5, 0, 0, 634, "R1 class5 no strap");
    threshold(5, 1, 0, 748, "R2 class5 sel01 oc");
    threshold(5, 2, 1, 900, "R2 R3 class5 sel10 startup");
    threshold(5, 3, 0, 836, "R2 class5 sel11 oc");
    threshold(5, 1, 1, 850, "R2 class5 sel01 startup");

    // R4 boundary: 59 ticks no trip, 60th trips next clock
    pdClass = 3'd0; class5Sel = 2'd0; curMa = 11'd500;
    powerOn(0); ticks(59);
    check(offReq == 0, "R4 59 ticks", offReq, 0);
    ticks(1);
    check(offReq == 1 && offCause == 1, "R4 60 ticks", {offReq, offCause}, 5);
    // R6 held while on, R7 saturation at full
    curMa = '0; ticks(5);
    check(offReq == 1, "R6 held while portOn", offReq, 1);
    powerOff();
    check(offReq == 0 && offCause == 0, "R10 cause cleared", offCause, 0);
    ticks(954);
    check(restartOk == 0, "R6 R7 drain not done", restartOk, 0);
    ticks(1);
    check(restartOk == 1, "R6 drain 960 from full", restartOk, 1);
    ticks(20);
    check(restartOk == 1, "R7 floor at zero", restartOk, 1);

    // R8 clear on entry: trip, re-enter at once, 59 more ticks safe
    curMa = 11'd500; powerOn(0); ticks(60); powerOff();
    check(restartOk == 0, "R6 not cleared by trip", restartOk, 0);
    powerOn(0); ticks(59);
    check(offReq == 0, "R8 cleared on entry", offReq, 0);
    powerOff();

    // R5 duty pattern: 1 over, 16 quiet never trips
    powerOn(0);
    for (int k = 0; k < 40; k++) begin
      curMa = 11'd500; ticks(1); curMa = 11'd100; ticks(16);
    end
    check(offReq == 0, "R5 balanced pattern", offReq, 0);
    // 1 over, 2 quiet accumulates to trip
    for (int k = 0; k < 80 && !offReq; k++) begin
      curMa = 11'd500; ticks(1); curMa = 11'd100; ticks(2);
    end
    check(offReq == 1 && offCause == 1, "R5 short overloads trip", {offReq, offCause}, 5);
    powerOff();

    // R9 disconnect
    dcDiscEn = 1'b1; curMa = 11'd7; powerOn(0); ticks(349);
    check(offReq == 0, "R9 349 ticks", offReq, 0);
    ticks(1);
    check(offReq == 1 && offCause == 2, "R9 R10 disconnect cause", {offReq, offCause}, 6);
    powerOff();
    curMa = 11'd8; powerOn(0); ticks(360);
    check(offReq == 0, "R9 8mA no trip", offReq, 0);
    powerOff();
    curMa = 11'd2; powerOn(1); ticks(360);
    check(offReq == 0, "R9 startup no trip", offReq, 0);
    powerOff();
    dcDiscEn = 1'b0; powerOn(0); ticks(360);
    check(offReq == 0, "R9 disabled no trip", offReq, 0);
    // R8 timer cleared: low current 200 ticks, re-enter, 200 more no trip
    dcDiscEn = 1'b1; powerOff(); powerOn(0); ticks(200); powerOff(); powerOn(0); ticks(200);
    check(offReq == 0, "R8 disconnect timer cleared", offReq, 0);
    powerOff();

    repeat (4) @(negedge clk);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule